// File: doc/BRIEF.md
# Interrupt Entry and Return Controller

This block owns the machine state register (MSR) and the two save/restore register pairs of a 64-bit processor core. It performs the two state changes around an interrupt. On entry it saves the interrupted PC and an image of the MSR into the ordinary pair (SRR0/SRR1) or the hypervisor pair (HSRR0/HSRR1), loads a new MSR and redirects fetch to the vector supplied by the requester. On a return instruction (rfid or hrfid) it restores the MSR from the matching pair and redirects fetch to the saved address.

The hypervisor-state bit of the MSR is hard-wired to one. External interrupts always use the hypervisor pair. The four save/restore registers can also be read and written directly through a small register port addressed by special-purpose register number. The redirect outputs and the MSR are registered, so each takes effect one clock after the request.

Top module: `trap_ctl`

## Requirements
- R1: MSR bit 60 (mask 0x1000_0000_0000_0000, hypervisor state) reads as 1 at all times, including after a return whose restored image has that bit clear.
- R2: An interrupt with `irq_hyp`=0 and `irq_ext`=0 writes SRR0 = `cur_pc` and SRR1 = the save image; HSRR0/HSRR1 keep their values.
- R3: An interrupt with `irq_hyp`=1 or `irq_ext`=1 writes HSRR0 = `cur_pc` and HSRR1 = the save image; SRR0/SRR1 keep their values. `irq_ext` alone is enough to select the hypervisor pair.
- R4: The save image is the current MSR (so bit 60 is 1, and bit 63 SF and bit 0 LE are as they stand), with bit 29 set when `irq_pfx`=1, and bit 28 set as well when `irq_pfx`=1 and `irq_pfx_align`=1.
- R5: One cycle after an interrupt request, `redirect_pc` = `irq_vec` and the MSR equals the old MSR with bits 15 (EE), 14 (PR), 5 (IR) and 4 (DR) cleared. All other bits are unchanged.
- R6: On `rfid_i`, one cycle later `redirect_pc` = SRR0 with bits 1:0 cleared, and the MSR = SRR1 with bit 60 forced to 1.
- R7: On `hrfid_i`, the same happens as for R6, but using HSRR0 and HSRR1.
- R8: When several requests arrive in the same cycle, an interrupt wins over both returns, and hrfid wins over rfid.
- R9: `spr_addr` 26, 27, 314 and 315 select SRR0, SRR1, HSRR0 and HSRR1. `spr_rdata` shows the selected register combinationally. `spr_we` writes it at the clock edge. Any other address reads 0, and writes to it change nothing.
- R10: A software write to a register of the pair that an interrupt entry writes in the same cycle is lost. A write to the other pair in that cycle takes effect.
- R11: After reset the MSR is 0x9000_0000_0000_0000, all four save/restore registers are 0 and `redirect_valid` is 0.
- R12: `redirect_valid` is high for exactly the cycle after each accepted interrupt or return, and is low after a cycle without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Take an interrupt this cycle |
| irq_hyp | input | 1 | Interrupt is hypervisor class |
| irq_ext | input | 1 | Interrupt is external (always hypervisor class) |
| irq_pfx | input | 1 | Interrupted instruction was prefixed |
| irq_pfx_align | input | 1 | Alignment-type cause on a prefixed instruction |
| irq_vec | input | 64 | Vector address to redirect to |
| cur_pc | input | 64 | PC of the interrupted instruction, saved as the return address |
| rfid_i | input | 1 | Decoded return using SRR0/SRR1 |
| hrfid_i | input | 1 | Decoded return using HSRR0/HSRR1 |
| spr_we | input | 1 | Register port write strobe |
| spr_addr | input | 10 | Register port SPR number |
| spr_wdata | input | 64 | Register port write data |
| spr_rdata | output | 64 | Register port read data |
| redirect_valid | output | 1 | One-cycle redirect strobe |
| redirect_pc | output | 64 | Redirect target |
| msr_o | output | 64 | Live MSR |

## Verification
An interrupt entry can meet a return instruction or a software register write in the same cycle. The bench forces both collisions directly. It raises an interrupt together with rfid and hrfid, raises rfid together with hrfid, and raises a hypervisor-class entry together with a write to HSRR0 and then to SRR0. It judges the redirect target, the MSR and the register readback against a bench model that applies the stated priorities. Random cycles then mix all requests freely against the same model.

// File: rtl/trap_pkg.sv
package trap_pkg;

   localparam int unsigned MSR_W    = 64;
   localparam int unsigned B_SF     = 63;
   localparam int unsigned B_HV     = 60;
   localparam int unsigned B_PFX    = 29;
   localparam int unsigned B_PFXALN = 28;
   localparam int unsigned B_EE     = 15;
   localparam int unsigned B_PR     = 14;
   localparam int unsigned B_IR     = 5;
   localparam int unsigned B_DR     = 4;
   localparam int unsigned B_LE     = 0;

   localparam logic [MSR_W-1:0] HV_MASK  = MSR_W'(1) << B_HV;
   localparam logic [MSR_W-1:0] ENTRY_CLR = (MSR_W'(1) << B_EE) | (MSR_W'(1) << B_PR)
                                          | (MSR_W'(1) << B_IR) | (MSR_W'(1) << B_DR);

   typedef enum logic [1:0] {EV_NONE, EV_ENTRY, EV_RET_STD, EV_RET_HYP} trap_ev_e;

   // Image stored in SRR1/HSRR1: live MSR plus prefixed-instruction cause bits.
   function automatic logic [MSR_W-1:0] save_image(input logic [MSR_W-1:0] msr,
                                                   input logic pfx, input logic aln);
      logic [MSR_W-1:0] img;
      img = msr;
      img[B_PFX]    = msr[B_PFX] | pfx;
      img[B_PFXALN] = msr[B_PFXALN] | (pfx & aln);
      return img;
   endfunction

endpackage

// File: rtl/trap_msr.sv
module trap_msr #(
   parameter int unsigned   W         = 64,
   parameter logic [W-1:0]  RESET_VAL = '0,
   parameter logic [W-1:0]  FIXED_ONE = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] nxt,
   output logic [W-1:0] msr_o
);

   if ((RESET_VAL & FIXED_ONE) != FIXED_ONE) begin : g_chk_reset
      $error("trap_msr: reset value must carry every fixed-one bit");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (FIXED_ONE[i]) begin : g_const
         assign msr_o[i] = 1'b1;
      end else begin : g_ff
         logic b;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  b <= RESET_VAL[i];
            else if (ld) b <= nxt[i];
         end
         assign msr_o[i] = b;
      end
   end

   // R6: loaded image appears on every writable bit
   assert_msr_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> ((msr_o & ~FIXED_ONE) == ($past(nxt) & ~FIXED_ONE)));
   assert_msr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(msr_o));

endmodule

// File: rtl/trap_pair.sv
module trap_pair #(
   parameter int unsigned W  = 64,
   parameter int unsigned AW = 10,
   parameter int unsigned A0 = 26,
   parameter int unsigned A1 = 27
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ent_we,
   input  logic [W-1:0]  ent_pc,
   input  logic [W-1:0]  ent_img,
   input  logic          spr_we,
   input  logic [AW-1:0] spr_addr,
   input  logic [W-1:0]  spr_wdata,
   output logic [W-1:0]  r0_o,
   output logic [W-1:0]  r1_o,
   output logic          sel0_o,
   output logic          sel1_o
);

   if (A0 >= (1 << AW) || A1 >= (1 << AW) || A0 == A1) begin : g_chk_addr
      $error("trap_pair: register numbers must be distinct and fit the address width");
   end

   assign sel0_o = (spr_addr == AW'(A0));
   assign sel1_o = (spr_addr == AW'(A1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r0_o <= '0;
         r1_o <= '0;
      end else if (ent_we) begin
         r0_o <= ent_pc;
         r1_o <= ent_img;
      end else if (spr_we) begin
         if (sel0_o) r0_o <= spr_wdata;
         if (sel1_o) r1_o <= spr_wdata;
      end
   end

   assert_entry_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ent_we |=> (r0_o == $past(ent_pc)) && (r1_o == $past(ent_img)));
   assert_pair_untouched_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ent_we && !spr_we) |=> $stable(r0_o) && $stable(r1_o));

endmodule

// File: rtl/trap_ctl.sv
module trap_ctl
   import trap_pkg::*;
#(
   parameter int unsigned      XLEN       = 64,
   parameter int unsigned      SPR_AW     = 10,
   parameter int unsigned      SPR_SRR0   = 26,
   parameter int unsigned      SPR_SRR1   = 27,
   parameter int unsigned      SPR_HSRR0  = 314,
   parameter int unsigned      SPR_HSRR1  = 315,
   parameter logic [XLEN-1:0]  RESET_MSR  = 64'h9000_0000_0000_0000,
   parameter logic [XLEN-1:0]  FIXED_ONE  = 64'h1000_0000_0000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req,
   input  logic              irq_hyp,
   input  logic              irq_ext,
   input  logic              irq_pfx,
   input  logic              irq_pfx_align,
   input  logic [XLEN-1:0]   irq_vec,
   input  logic [XLEN-1:0]   cur_pc,
   input  logic              rfid_i,
   input  logic              hrfid_i,
   input  logic              spr_we,
   input  logic [SPR_AW-1:0] spr_addr,
   input  logic [XLEN-1:0]   spr_wdata,
   output logic [XLEN-1:0]   spr_rdata,
   output logic              redirect_valid,
   output logic [XLEN-1:0]   redirect_pc,
   output logic [XLEN-1:0]   msr_o
);

   if (XLEN != MSR_W) begin : g_chk_xlen
      $error("trap_ctl: architected bit positions require a 64-bit MSR");
   end

   localparam int unsigned NPAIR = 2;   // index 0 ordinary, 1 hypervisor

   logic [XLEN-1:0] r0 [NPAIR];
   logic [XLEN-1:0] r1 [NPAIR];
   logic [NPAIR-1:0] sel0, sel1, ent_we;
   logic             to_hyp;
   logic [XLEN-1:0]  img, msr_nxt, ret_pc;
   trap_ev_e         ev;

   assign to_hyp = irq_hyp | irq_ext;
   assign img    = save_image(msr_o, irq_pfx, irq_pfx_align);
   assign ent_we = {irq_req & to_hyp, irq_req & ~to_hyp};

   always_comb begin
      if (irq_req)      ev = EV_ENTRY;
      else if (hrfid_i) ev = EV_RET_HYP;
      else if (rfid_i)  ev = EV_RET_STD;
      else              ev = EV_NONE;
   end

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      trap_pair #(
         .W(XLEN), .AW(SPR_AW),
         .A0(p == 0 ? SPR_SRR0 : SPR_HSRR0),
         .A1(p == 0 ? SPR_SRR1 : SPR_HSRR1)
      ) u_pair (
         .clk(clk), .rst_n(rst_n),
         .ent_we(ent_we[p]), .ent_pc(cur_pc), .ent_img(img),
         .spr_we(spr_we), .spr_addr(spr_addr), .spr_wdata(spr_wdata),
         .r0_o(r0[p]), .r1_o(r1[p]), .sel0_o(sel0[p]), .sel1_o(sel1[p])
      );
   end

   always_comb begin
      msr_nxt = msr_o;
      ret_pc  = '0;
      unique case (ev)
         EV_ENTRY:   msr_nxt = msr_o & ~ENTRY_CLR;
         EV_RET_HYP: begin msr_nxt = r1[1]; ret_pc = {r0[1][XLEN-1:2], 2'b00}; end
         EV_RET_STD: begin msr_nxt = r1[0]; ret_pc = {r0[0][XLEN-1:2], 2'b00}; end
         default:    ;
      endcase
   end

   trap_msr #(.W(XLEN), .RESET_VAL(RESET_MSR), .FIXED_ONE(FIXED_ONE)) u_msr (
      .clk(clk), .rst_n(rst_n), .ld(ev != EV_NONE), .nxt(msr_nxt), .msr_o(msr_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         redirect_valid <= 1'b0;
         redirect_pc    <= '0;
      end else begin
         redirect_valid <= (ev != EV_NONE);
         if (ev == EV_ENTRY)    redirect_pc <= irq_vec;
         else if (ev != EV_NONE) redirect_pc <= ret_pc;
      end
   end

   always_comb begin
      spr_rdata = '0;
      for (int p = 0; p < NPAIR; p++) begin
         if (sel0[p]) spr_rdata = r0[p];
         if (sel1[p]) spr_rdata = r1[p];
      end
   end

   assert_entry_redirect_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |=> redirect_valid && (redirect_pc == $past(irq_vec)) && ((msr_o & ENTRY_CLR) == '0));
   assert_ext_hyp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ext && !spr_we) |=> (r0[1] == $past(cur_pc)) && $stable(r0[0]) && $stable(r1[0]));
   assert_hrfid_over_rfid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rfid_i && hrfid_i && !irq_req) |=> (redirect_pc == {$past(r0[1][XLEN-1:2]), 2'b00}));
   assert_ret_hv_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ((rfid_i || hrfid_i) && !irq_req) |=> msr_o[B_HV] && (redirect_pc[1:0] == 2'b00));
   assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_req || rfid_i || hrfid_i) |=> !redirect_valid);

endmodule

// File: tb/tb_trap_ctl.sv
`timescale 1ns/1ps
module tb_trap_ctl;

   localparam logic [63:0] HV   = 64'h1000_0000_0000_0000;
   localparam logic [63:0] CLRM = 64'h0000_0000_0000_C030;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        irq_req = 0, irq_hyp = 0, irq_ext = 0, irq_pfx = 0, irq_pfx_align = 0;
   logic [63:0] irq_vec = '0, cur_pc = '0, spr_wdata = '0;
   logic        rfid_i = 0, hrfid_i = 0, spr_we = 0;
   logic [9:0]  spr_addr = '0;
   logic [63:0] spr_rdata, redirect_pc, msr_o;
   logic        redirect_valid;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // bench model
   logic [63:0] m_s0 = 0, m_s1 = 0, m_h0 = 0, m_h1 = 0, m_msr = 64'h9000_0000_0000_0000;
   logic [63:0] m_pc = 0;
   bit          m_v = 0;

   trap_ctl dut (.*);

   always #4 clk = ~clk;

   function automatic logic [63:0] exp_img(input logic [63:0] m, input bit p, input bit a);
      logic [63:0] r;
      r = m;
      if (p) r = r | (64'd1 << 29);
      if (p && a) r = r | (64'd1 << 28);
      return r;
   endfunction

   function automatic logic [63:0] m_read(input logic [9:0] a);
      case (a)
         10'd26:  return m_s0;
         10'd27:  return m_s1;
         10'd314: return m_h0;
         10'd315: return m_h1;
         default: return 64'd0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input bit req, input bit hyp, input bit ext, input bit pfx, input bit aln,
                       input logic [63:0] vec, input logic [63:0] pc, input bit rf, input bit hrf,
                       input bit we, input logic [9:0] addr, input logic [63:0] wd,
                       input string tag);
      bit th;
      logic [63:0] im;
      irq_req = req; irq_hyp = hyp; irq_ext = ext; irq_pfx = pfx; irq_pfx_align = aln;
      irq_vec = vec; cur_pc = pc; rfid_i = rf; hrfid_i = hrf;
      spr_we = we; spr_addr = addr; spr_wdata = wd;
      // model update from pre-edge state
      th  = hyp | ext;
      im  = exp_img(m_msr, pfx, aln);
      m_v = req | rf | hrf;
      if (req) begin
         m_pc = vec;
         m_msr = m_msr & ~CLRM;
      end else if (hrf) begin
         m_pc = {m_h0[63:2], 2'b00};
         m_msr = m_h1 | HV;
      end else if (rf) begin
         m_pc = {m_s0[63:2], 2'b00};
         m_msr = m_s1 | HV;
      end
      if (we && !(req && !th)) begin
         if (addr == 10'd26) m_s0 = wd;
         if (addr == 10'd27) m_s1 = wd;
      end
      if (we && !(req && th)) begin
         if (addr == 10'd314) m_h0 = wd;
         if (addr == 10'd315) m_h1 = wd;
      end
      if (req && th)  begin m_h0 = pc; m_h1 = im; end
      if (req && !th) begin m_s0 = pc; m_s1 = im; end
      @(posedge clk);
      @(negedge clk);
      irq_req = 0; rfid_i = 0; hrfid_i = 0; spr_we = 0;
      chk({tag, " R12 valid"}, 64'(redirect_valid), 64'(m_v));
      if (m_v) chk({tag, " redirect_pc"}, redirect_pc, m_pc);
      chk({tag, " msr"}, msr_o, m_msr);
      chk({tag, " R1 hv"}, 64'(msr_o[60]), 64'd1);
      chk({tag, " R9 rdata"}, spr_rdata, m_read(addr));
   endtask

   task automatic idle_read(input logic [9:0] a, input string tag);
      step(0,0,0,0,0, 0, 0, 0,0, 0, a, 0, tag);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7731));
      repeat (3) @(negedge clk);
      // R11 reset state, sampled while still in reset and just after
      chk("R11 msr", msr_o, 64'h9000_0000_0000_0000);
      chk("R11 valid", 64'(redirect_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      idle_read(10'd26, "R11 srr0");
      idle_read(10'd27, "R11 srr1");
      idle_read(10'd314, "R11 hsrr0");
      idle_read(10'd315, "R11 hsrr1");

      // R9 register port
      step(0,0,0,0,0, 0,0, 0,0, 1, 10'd26,  64'h0000_0000_0000_1237, "R9 w srr0");
      step(0,0,0,0,0, 0,0, 0,0, 1, 10'd27,  64'h8000_0000_0000_8031, "R9 w srr1");
      step(0,0,0,0,0, 0,0, 0,0, 1, 10'd314, 64'h0000_0000_0000_4446, "R9 w hsrr0");
      step(0,0,0,0,0, 0,0, 0,0, 1, 10'd315, 64'h0000_0000_0000_0000, "R9 w hsrr1");
      step(0,0,0,0,0, 0,0, 0,0, 1, 10'd100, 64'hdead_beef_dead_beef, "R9 ignored addr");
      idle_read(10'd26, "R9 srr0 after stray write");

      // R7 and R1: hrfid restores an image with HV clear
      step(0,0,0,0,0, 0,0, 0,1, 0, 10'd0, 0, "R7 hrfid");
      // R6 rfid
      step(0,0,0,0,0, 0,0, 1,0, 0, 10'd0, 0, "R6 rfid");
      // R2 + R4 ordinary interrupt, prefixed with alignment cause
      step(1,0,0,1,1, 64'h700, 64'h2000, 0,0, 0, 10'd27, 0, "R2 R4 R5 ordinary entry");
      idle_read(10'd26, "R2 srr0");
      idle_read(10'd314, "R2 hsrr0 untouched");
      // R3 external interrupt with hyp flag clear
      step(1,0,1,1,0, 64'h500, 64'h3004, 0,0, 0, 10'd315, 0, "R3 R4 external entry");
      idle_read(10'd314, "R3 hsrr0");
      idle_read(10'd26, "R3 srr0 untouched");
      // R8 priorities
      step(1,1,0,0,0, 64'h980, 64'h4008, 1,1, 0, 10'd0, 0, "R8 irq beats returns");
      step(0,0,0,0,0, 0,0, 1,1, 0, 10'd0, 0, "R8 hrfid beats rfid");
      // R10 collision of entry with software writes
      step(1,1,0,0,0, 64'hE80, 64'h5000, 0,0, 1, 10'd314, 64'h1111, "R10 write lost");
      idle_read(10'd314, "R10 hsrr0 after");
      step(1,1,0,0,0, 64'hE80, 64'h6000, 0,0, 1, 10'd26, 64'h2222, "R10 other pair write");
      idle_read(10'd26, "R10 srr0 after");
      // R12 idle after event
      idle_read(10'd0, "R12 idle");

      // random mix
      for (int i = 0; i < 3000; i++) begin
         bit req, rf, hrf, we;
         logic [9:0] a;
         string t;
         req = ($urandom_range(0, 3) == 0);
         rf  = ($urandom_range(0, 4) == 0);
         hrf = ($urandom_range(0, 4) == 0);
         we  = ($urandom_range(0, 2) == 0);
         case ($urandom_range(0, 4))
            0: a = 10'd26;
            1: a = 10'd27;
            2: a = 10'd314;
            3: a = 10'd315;
            default: a = 10'($urandom);
         endcase
         t = req ? "R5 rnd entry" : hrf ? "R7 rnd hrfid" : rf ? "R6 rnd rfid" : "R9 rnd port";
         step(req, 1'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom),
              {$urandom, $urandom}, {$urandom, $urandom}, rf, hrf,
              we, a, {$urandom, $urandom}, t);
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule